// File: doc/BRIEF.md
# Grouped Level-Interrupt Combiner

The combiner gathers a large set of level-sensitive interrupt lines into groups of eight and gives each group a single request line toward a parent interrupt controller. A source is pending while its input is high. It takes part in its group's request only while its enable bit is set. Nothing is latched, so a pending bit drops as soon as the input goes low.

Software reaches the block through a plain register bus. That bus has an address, write data, a write strobe, a read strobe and registered read data. Four groups share one 32-bit register bank, and each group owns one byte lane of it. Banks repeat every 0x10 bytes. Enables are never written directly. One register turns enable bits on and another turns them off, so drivers that touch different sources need no read-modify-write. A third register reports the sources that are both pending and enabled.

Top module: `irqcomb_top`

## Requirements
- R1: After synchronous reset, every enable bit is 0, every `irq_out` bit is 0 and `bus_rdata` is 0.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A read of offset 0x0 or 0x4 returns the bank's current 32-bit enable mask.
- R5: A read of offset 0xC returns `src & enable` for the bank. Source s sits in group s/8, bank s/32, and bit (s mod 32) of that bank's word, so group g occupies bits [(g mod 4)*8 +: 8]. Status follows the input level with no latching and no clear on read.
- R6: Bit g of `irq_out` is the OR of group g's eight enabled-and-pending bits, registered once. It is high one clock edge after that OR becomes true and low one edge after it becomes false.
- R7: Bank b answers at address 0x10*b. The only mapped offsets are 0x0, 0x4 and 0xC, and each must have address bits [1:0] equal to 0. An access to offset 0x8, to an address whose bits [1:0] are not 0, or to a bank index at or above the bank count reads 0 and changes no enable.
- R8: `bus_rdata` is loaded at the clock edge that samples `bus_rd`. It holds 0 after any edge at which `bus_rd` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | NUM_GROUPS*8 | Level interrupt inputs, source s on bit s |
| bus_addr | input | ADDR_W | Byte address: bank index in [ADDR_W-1:4], register offset in [3:0] |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | NUM_GROUPS | One combined request per group |

## Verification
An enable write takes effect at the edge that samples the strobe, and `irq_out` follows one edge after that. The bench therefore checks group outputs only after two falling edges with the stimulus held. Read data is due at the edge that samples `bus_rd`. The bench drives each strobe for one cycle from a falling edge and samples `bus_rdata` at the next falling edge. It samples again one falling edge later to confirm that the value has returned to 0. A change on `src` reaches the status word at once and `irq_out` one edge later, and both are checked against a bench model of the enables.

// File: rtl/irqcomb_pkg.sv
package irqcomb_pkg;

    localparam int LANE_W         = 8;
    localparam int LANES_PER_BANK = 4;
    localparam int WORD_W         = LANE_W * LANES_PER_BANK;
    localparam int OFS_BITS       = 4;

    // Register select taken from address bits [3:2]
    typedef enum logic [1:0] {
        SEL_EN_SET = 2'd0,
        SEL_EN_CLR = 2'd1,
        SEL_HOLE   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [WORD_W-1:0] wdata;
    } bank_req_t;

    function automatic int banks_for(input int groups);
        return (groups + LANES_PER_BANK - 1) / LANES_PER_BANK;
    endfunction

    function automatic int lanes_in_bank(input int groups, input int bank);
        int left;
        left = groups - bank * LANES_PER_BANK;
        return (left >= LANES_PER_BANK) ? LANES_PER_BANK : left;
    endfunction

    function automatic logic [WORD_W-1:0] lane_keep(input int used);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANES_PER_BANK; i++) begin
            if (i < used) m[i*LANE_W +: LANE_W] = {LANE_W{1'b1}};
        end
        return m;
    endfunction

endpackage

// File: rtl/irqcomb_decode.sv
module irqcomb_decode
    import irqcomb_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [NUM_BANKS-1:0] bank_hit,
    output bank_req_t         req
);

    localparam int BIDX_W = ADDR_W - OFS_BITS;

    logic     aligned;
    logic     mapped;
    reg_sel_e sel;

    always_comb begin
        sel     = reg_sel_e'(addr[3:2]);
        aligned = (addr[1:0] == 2'b00);
        mapped  = aligned && (sel != SEL_HOLE);
        req.wr    = wr;
        req.rd    = rd;
        req.sel   = sel;
        req.wdata = wdata;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign bank_hit[b] = mapped && (addr[ADDR_W-1:OFS_BITS] == BIDX_W'(b));
    end

endmodule

// File: rtl/irqcomb_bank.sv
module irqcomb_bank
    import irqcomb_pkg::*;
#(
    parameter int LANES_USED = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      hit,
    input  bank_req_t                 req,
    input  logic [WORD_W-1:0]         src_word,
    output logic [WORD_W-1:0]         rdata,
    output logic [LANES_PER_BANK-1:0] irq
);

    localparam logic [WORD_W-1:0] KEEP = lane_keep(LANES_USED);

    logic [WORD_W-1:0]         en_q;
    logic [WORD_W-1:0]         en_d;
    logic [WORD_W-1:0]         pend;
    logic [LANES_PER_BANK-1:0] irq_q;
    logic                      wr_hit;

    assign wr_hit = hit && req.wr;

    always_comb begin
        en_d = en_q;
        if (wr_hit) begin
            unique case (req.sel)
                SEL_EN_SET: en_d = en_q | (req.wdata & KEEP);
                SEL_EN_CLR: en_d = en_q & ~req.wdata;
                default:    en_d = en_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    assign pend = src_word & en_q;

    always_comb begin
        rdata = '0;
        if (hit && req.rd) begin
            rdata = (req.sel == SEL_STATUS) ? pend : en_q;
        end
    end

    for (genvar l = 0; l < LANES_PER_BANK; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) irq_q[l] <= 1'b0;
            else     irq_q[l] <= |pend[l*LANE_W +: LANE_W];
        end

        AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
            irq_q[l] |-> $past(|src_word[l*LANE_W +: LANE_W])); // R6
    end

    assign irq = irq_q;

    AST_RESET_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0) && (irq_q == '0)); // R1

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && req.sel == SEL_EN_SET) |=>
        ((en_q & $past(req.wdata & KEEP)) == $past(req.wdata & KEEP))); // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && req.sel == SEL_EN_CLR) |=> ((en_q & $past(req.wdata)) == '0)); // R3

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(en_q)); // R7

endmodule

// File: rtl/irqcomb_rdmux.sv
module irqcomb_rdmux
    import irqcomb_pkg::*;
#(
    parameter int NUM_BANKS = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd,
    input  logic [NUM_BANKS*WORD_W-1:0] bank_rdata,
    output logic [WORD_W-1:0]           rdata
);

    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] rdata_q;

    always_comb begin
        merged = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            merged = merged | bank_rdata[b*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata_q <= '0;
        else if (rd) rdata_q <= merged;
        else         rdata_q <= '0;
    end

    assign rdata = rdata_q;

    AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (rdata_q == '0)); // R8

endmodule

// File: rtl/irqcomb_top.sv
module irqcomb_top
    import irqcomb_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_GROUPS*LANE_W-1:0] src,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [WORD_W-1:0]            bus_wdata,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    output logic [WORD_W-1:0]            bus_rdata,
    output logic [NUM_GROUPS-1:0]        irq_out
);

    localparam int NUM_SRC   = NUM_GROUPS * LANE_W;
    localparam int NUM_BANKS = banks_for(NUM_GROUPS);

    logic [NUM_BANKS-1:0]                bank_hit;
    bank_req_t                           req;
    logic [NUM_BANKS*WORD_W-1:0]         src_pad;
    logic [NUM_BANKS*WORD_W-1:0]         bank_rdata;
    logic [NUM_BANKS*LANES_PER_BANK-1:0] irq_all;

    always_comb begin
        src_pad = '0;
        src_pad[NUM_SRC-1:0] = src;
    end

    irqcomb_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .bank_hit (bank_hit),
        .req      (req)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int USED = lanes_in_bank(NUM_GROUPS, b);

        irqcomb_bank #(
            .LANES_USED (USED)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .hit      (bank_hit[b]),
            .req      (req),
            .src_word (src_pad[b*WORD_W +: WORD_W]),
            .rdata    (bank_rdata[b*WORD_W +: WORD_W]),
            .irq      (irq_all[b*LANES_PER_BANK +: LANES_PER_BANK])
        );
    end

    irqcomb_rdmux #(
        .NUM_BANKS (NUM_BANKS)
    ) u_rdmux (
        .clk        (clk),
        .rst        (rst),
        .rd         (bus_rd),
        .bank_rdata (bank_rdata),
        .rdata      (bus_rdata)
    );

    assign irq_out = irq_all[NUM_GROUPS-1:0];

    AST_ONE_BANK_SELECTED: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_hit)); // R7

endmodule

// File: tb/tb_irqcomb_top.sv
module tb_irqcomb_top;

    localparam int NG      = 20;
    localparam int NS      = NG * 8;
    localparam int NB      = (NG + 3) / 4;
    localparam int AW      = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src = '0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic [NG-1:0] irq_out;

    logic [NS-1:0] en_model = '0;
    int            n_checks = 0;
    int            n_fails  = 0;
    bit            done     = 1'b0;

    always #4 clk = ~clk;

    irqcomb_top #(.NUM_GROUPS(NG), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .src(src), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic bit is_mapped(input logic [AW-1:0] a);
        return (a[1:0] == 2'b00) && (a[3:2] != 2'd2) && (int'(a[AW-1:4]) < NB);
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        int b;
        if (!is_mapped(a)) return 32'h0;
        b = int'(a[AW-1:4]);
        if (a[3:2] == 2'd3) return src[b*32 +: 32] & en_model[b*32 +: 32];
        return en_model[b*32 +: 32];
    endfunction

    function automatic logic [NG-1:0] exp_irq();
        logic [NG-1:0] r;
        logic [NS-1:0] p;
        p = src & en_model;
        for (int g = 0; g < NG; g++) r[g] = |p[g*8 +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [159:0] act,
                         input logic [159:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        int b;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (is_mapped(a)) begin
            b = int'(a[AW-1:4]);
            if (a[3:2] == 2'd0) en_model[b*32 +: 32] = en_model[b*32 +: 32] | d;
            if (a[3:2] == 2'd1) en_model[b*32 +: 32] = en_model[b*32 +: 32] & ~d;
        end
    endtask

    task automatic bus_read_check(input logic [AW-1:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        e = exp_read(a);
        @(negedge clk);
        bus_rd = 1'b0;
        check(bus_rdata == e, tag, 160'(bus_rdata), 160'(e));
        @(negedge clk);
        check(bus_rdata == 32'h0, "R8 idle read data", 160'(bus_rdata), 160'h0);
    endtask

    task automatic irq_check(input string tag);
        @(negedge clk);
        @(negedge clk);
        check(irq_out == exp_irq(), tag, 160'(irq_out), 160'(exp_irq()));
    endtask

    task automatic check_all_enables(input string tag);
        for (int b = 0; b < NB; b++) bus_read_check(AW'(b * 16), tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        rv = $urandom(32'h5eed1234);
        src = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(irq_out == '0, "R1 irq after reset", 160'(irq_out), 160'h0);
        check(bus_rdata == '0, "R1 rdata after reset", 160'(bus_rdata), 160'h0);
        bus_read_check(8'h00, "R1 enables zero bank0");
        bus_read_check(8'h4C, "R1 status zero bank4");
        src = '0;

        // R2: set source 0 and source 159 (group 19 bit 7 -> bank 4 bit 31)
        bus_write(8'h00, 32'h0000_0001);
        bus_write(8'h40, 32'h8000_0000);
        bus_read_check(8'h04, "R4 enable via clear offset");
        bus_read_check(8'h40, "R2 set bank4 bit31");
        bus_write(8'h00, 32'h0000_0000);
        bus_read_check(8'h00, "R2 zero set no effect");

        // R5/R6: source 159 high -> group 19
        src[159] = 1'b1;
        irq_check("R6 group19 up");
        bus_read_check(8'h4C, "R5 status bit31 bank4");
        src[159] = 1'b0;
        irq_check("R6 group19 down");
        bus_read_check(8'h4C, "R5 no latching");

        // R5: disabled source stays invisible (source 42 -> group 5, bank 1 bit 10)
        src[42] = 1'b1;
        irq_check("R5 disabled source masked");
        bus_write(8'h10, 32'h0000_0400);
        irq_check("R6 group5 after enable");
        bus_read_check(8'h1C, "R5 source42 at bank1 bit10");

        // R3: clear with zeros keeps, ones clear
        bus_write(8'h14, 32'h0000_0000);
        bus_read_check(8'h10, "R3 zero clear no effect");
        bus_write(8'h14, 32'h0000_0400);
        bus_read_check(8'h10, "R3 clear bit10");
        irq_check("R3 group5 drops after clear");

        // R7: unmapped accesses
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h50, 32'hFFFF_FFFF);
        bus_write(8'h21, 32'hFFFF_FFFF);
        bus_write(8'hF0, 32'hFFFF_FFFF);
        check_all_enables("R7 unmapped writes ignored");
        irq_check("R7 irq unchanged");
        bus_read_check(8'h08, "R7 hole reads zero");
        bus_read_check(8'h50, "R7 bank beyond count reads zero");
        bus_read_check(8'h01, "R7 misaligned reads zero");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            int b;
            op = int'($urandom_range(0, 4));
            b  = int'($urandom_range(0, NB));
            case (op)
                0: bus_write(AW'(b * 16), $urandom());
                1: bus_write(AW'(b * 16 + 4), $urandom());
                2: begin
                    @(negedge clk);
                    for (int w = 0; w < NB; w++) src[w*32 +: 32] = $urandom() & $urandom();
                    irq_check("R6 random irq");
                end
                3: bus_read_check(AW'(b * 16 + 12), "R5 random status");
                default: bus_read_check(AW'(b * 16 + 4 * int'($urandom_range(0, 3))),
                                        "R4 random read");
            endcase
        end
        irq_check("R6 final irq");
        check_all_enables("R4 final enables");
        finish_run();
    end

endmodule